// File: doc/BRIEF.md
# Command-Driven Ring Buffer Queue

This block is a first-in first-out queue of data words. The words live in one flat storage array that is used as a ring. A read index points at the oldest word and a write index points at the next free slot. An occupancy count between zero and the depth decides whether the queue is empty or full. Each request carries one of three commands. A push stores the request's data word. A pop returns the oldest word and removes it. A peek returns the oldest word and leaves it in place. Pop and peek share one read path. A pop also advances the read index and lowers the count.

Requests use a valid/ready handshake. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The queue can take a new request on every cycle, so `req_ready` is held low only while reset is asserted. The requester must hold `req_valid`, `req_cmd` and `req_data` steady until the request is accepted. The response has no back-pressure. In the cycle after acceptance, `rsp_done` pulses for one cycle, `rsp_err` reports the outcome, and `rsp_answer` holds the result. On an error the answer register keeps its previous contents.

The `POW2_WRAP` parameter picks how the indices wrap. With `POW2_WRAP` = 0, each index is compared against the last slot and cleared after it. With `POW2_WRAP` = 1, the depth must be a power of two, and the indices count freely and wrap by overflow.

Top module: `cmd_ring_queue`

## Requirements
- R1: While `rst` is high, `req_ready` is 0. After a synchronous reset the queue is empty, and `rsp_done`, `rsp_err` and `rsp_answer` are all 0.
- R2: Outside reset `req_ready` is 1. Each accepted request produces `rsp_done` = 1 in the next cycle. `rsp_done` is 0 in the cycle after a cycle with no acceptance.
- R3: Push (`req_cmd` = 2'b10) on a queue that is not full stores `req_data`, reports `rsp_err` = 0 and leaves `rsp_answer` unchanged.
- R4: Pop (`req_cmd` = 2'b00) on a queue that is not empty returns the oldest word on `rsp_answer` with `rsp_err` = 0, and removes that word. Words leave in the order they were pushed.
- R5: Peek (`req_cmd` = 2'b01) on a queue that is not empty returns the oldest word with `rsp_err` = 0 and does not remove it. The next pop returns the same word.
- R6: Push on a full queue (DEPTH words held) reports `rsp_err` = 1 and changes neither the stored words nor the occupancy.
- R7: Pop or peek on an empty queue reports `rsp_err` = 1. `rsp_answer` keeps the value it held before the request.
- R8: The unused command code 2'b11 reports `rsp_err` = 1 and changes no queue state and no answer.
- R9: FIFO order is kept when the indices wrap past the last slot. This holds in compare mode (`POW2_WRAP` = 0, any DEPTH) and in overflow mode (`POW2_WRAP` = 1, DEPTH a power of two).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request |
| req_cmd | input | 2 | Command: 00 pop, 01 peek, 10 push, 11 unused |
| req_data | input | WIDTH | Word to store on a push |
| rsp_done | output | 1 | One-cycle pulse, one cycle after acceptance |
| rsp_err | output | 1 | Outcome of the latest request, 1 if it was refused |
| rsp_answer | output | WIDTH | Word from the latest successful pop or peek |

## Verification
The hardest situation to reach is a wrapped index that meets a boundary at the same time. One case is a full queue whose write index has already crossed the last slot. Another is an empty queue whose read index sits in the middle of the ring. The stimulus table first moves both indices forward with a few pushes and pops. It then fills the queue so the write index wraps, rejects an extra push and an unused code, and drains the queue back to empty. A second instance with a depth of three runs in compare mode. It gets a directed sequence that wraps the write index and then hits the full boundary.

// File: rtl/ring_queue_pkg.sv
package ring_queue_pkg;
  typedef enum logic [1:0] {
    CMD_POP  = 2'b00,
    CMD_PEEK = 2'b01,
    CMD_PUSH = 2'b10
  } q_cmd_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH = 4,
  parameter bit POW2  = 1'b1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] idx
);
  logic [AW-1:0] nxt;

  generate
    if (POW2) begin : g_overflow
      assign nxt = idx + 1'b1;
    end else begin : g_compare
      assign nxt = (idx == AW'(DEPTH - 1)) ? '0 : idx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= nxt;
  end

  // R9: an index never points outside the storage
  a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, idx} < (AW+1)'(DEPTH));
endmodule

// File: rtl/occ_count.sv
module occ_count #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
    else if (dec) count <= count - 1'b1;
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R6: occupancy stays within the depth
  a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R6: the control never asks for a store into a full queue
  a_r6_no_inc_when_full: assert property (@(posedge clk) disable iff (rst)
    !(inc && full));
  // R7: the control never removes from an empty queue
  a_r7_no_dec_when_empty: assert property (@(posedge clk) disable iff (rst)
    !(dec && empty));
endmodule

// File: rtl/ring_mem.sv
module ring_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/cmd_ring_queue.sv
module cmd_ring_queue
  import ring_queue_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 4,
  parameter bit POW2_WRAP = 1'b1,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_cmd,
  input  logic [WIDTH-1:0] req_data,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [WIDTH-1:0] rsp_answer
);
  logic          acc, is_push, is_read, is_pop;
  logic          push_ok, read_ok, pop_ok, refused;
  logic [AW-1:0] rd_idx, wr_idx;
  logic [CW-1:0] occ;
  logic          full, empty;
  logic [WIDTH-1:0] head;

  assign req_ready = !rst;
  assign acc       = req_valid && req_ready;
  assign is_push   = (req_cmd == CMD_PUSH);
  assign is_pop    = (req_cmd == CMD_POP);
  assign is_read   = is_pop || (req_cmd == CMD_PEEK);
  assign push_ok   = acc && is_push && !full;
  assign read_ok   = acc && is_read && !empty;
  assign pop_ok    = read_ok && is_pop;
  assign refused   = acc && !(push_ok || read_ok);

  ring_ptr #(.DEPTH(DEPTH), .POW2(POW2_WRAP)) i_wr_ptr (
    .clk(clk), .rst(rst), .adv(push_ok), .idx(wr_idx));

  ring_ptr #(.DEPTH(DEPTH), .POW2(POW2_WRAP)) i_rd_ptr (
    .clk(clk), .rst(rst), .adv(pop_ok), .idx(rd_idx));

  occ_count #(.DEPTH(DEPTH)) i_occ (
    .clk(clk), .rst(rst), .inc(push_ok), .dec(pop_ok),
    .count(occ), .full(full), .empty(empty));

  ring_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_mem (
    .clk(clk), .we(push_ok), .waddr(wr_idx), .wdata(req_data),
    .raddr(rd_idx), .rdata(head));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done   <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_answer <= '0;
    end else begin
      rsp_done <= acc;
      if (acc)     rsp_err    <= refused;
      if (read_ok) rsp_answer <= head;
    end
  end

  // R2: every acceptance is answered in the next cycle
  a_r2_done_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_done);
  // R2: no response without an acceptance
  a_r2_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_done);
  // R6: a push on a full queue is reported as an error
  a_r6_full_push_err: assert property (@(posedge clk) disable iff (rst)
    (acc && is_push && full) |=> rsp_err);
  // R7: a read on an empty queue is reported as an error
  a_r7_empty_read_err: assert property (@(posedge clk) disable iff (rst)
    (acc && is_read && empty) |=> rsp_err);
  // R7: an error response keeps the earlier answer
  a_r7_answer_held: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_err) |-> $stable(rsp_answer));
  // R8: an unused code is refused
  a_r8_bad_code_err: assert property (@(posedge clk) disable iff (rst)
    (acc && req_cmd == 2'b11) |=> rsp_err);
endmodule

// File: tb/test_cmd_ring_queue.sv
module test_cmd_ring_queue;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [W-1:0] req_data = '0;
  logic a_ready, a_done, a_err;
  logic [W-1:0] a_ans;
  logic b_ready, b_done, b_err;
  logic [W-1:0] b_ans;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ring_queue #(.WIDTH(W), .DEPTH(4), .POW2_WRAP(1'b1)) i_cmd_ring_queue (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(a_ready),
    .req_cmd(req_cmd), .req_data(req_data), .rsp_done(a_done),
    .rsp_err(a_err), .rsp_answer(a_ans));

  cmd_ring_queue #(.WIDTH(W), .DEPTH(3), .POW2_WRAP(1'b0)) i_cmd_ring_queue_cmp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(b_ready),
    .req_cmd(req_cmd), .req_data(req_data), .rsp_done(b_done),
    .rsp_err(b_err), .rsp_answer(b_ans));

  // vector: {cmd, data, expected err, expected answer}
  typedef struct packed {
    logic [1:0]   cmd;
    logic [W-1:0] data;
    logic         err;
    logic [W-1:0] ans;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 8'h00, 1'b1, 8'h00},  // R7 pop on empty
    '{2'b10, 8'h11, 1'b0, 8'h00},  // R3 push
    '{2'b10, 8'h22, 1'b0, 8'h00},  // R3 push
    '{2'b01, 8'h00, 1'b0, 8'h11},  // R5 peek
    '{2'b00, 8'h00, 1'b0, 8'h11},  // R5 pop after peek returns same word
    '{2'b00, 8'h00, 1'b0, 8'h22},  // R4 order
    '{2'b01, 8'h00, 1'b1, 8'h22},  // R7 peek on empty keeps answer
    '{2'b10, 8'h33, 1'b0, 8'h22},  // R9 fill, write index wraps
    '{2'b10, 8'h44, 1'b0, 8'h22},
    '{2'b10, 8'h55, 1'b0, 8'h22},
    '{2'b10, 8'h66, 1'b0, 8'h22},
    '{2'b10, 8'h77, 1'b1, 8'h22},  // R6 push on full
    '{2'b11, 8'h99, 1'b1, 8'h22},  // R8 unused code
    '{2'b00, 8'h00, 1'b0, 8'h33},  // R9 drain in order
    '{2'b00, 8'h00, 1'b0, 8'h44},
    '{2'b01, 8'h00, 1'b0, 8'h55},
    '{2'b00, 8'h00, 1'b0, 8'h55},
    '{2'b00, 8'h00, 1'b0, 8'h66},  // R6 rejected 77 never appears
    '{2'b00, 8'h00, 1'b1, 8'h66}   // R7 empty again
  };

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at the falling edge, accept at the rising edge, sample at the next falling edge
  task automatic issue(input logic [1:0] cmd, input logic [W-1:0] data);
    req_valid = 1'b1;
    req_cmd   = cmd;
    req_data  = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 ready low in reset", W'(a_ready), W'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", W'(a_done), W'(0));
    check("R1 err after reset", W'(a_err), W'(0));
    check("R1 answer after reset", a_ans, W'(0));
    check("R2 ready high", W'(a_ready), W'(1));

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].cmd, VECS[i].data);
      check($sformatf("R2 done vec %0d", i), W'(a_done), W'(1));
      check($sformatf("err vec %0d", i), W'(a_err), W'(VECS[i].err));
      check($sformatf("answer vec %0d", i), a_ans, VECS[i].ans);
    end

    // R2: idle cycle gives no done pulse
    @(negedge clk);
    check("R2 no done when idle", W'(a_done), W'(0));

    // R9: compare-mode instance, depth 3
    do_reset();
    check("R1 cmp answer after reset", b_ans, W'(0));
    issue(2'b10, 8'hA1);
    issue(2'b10, 8'hA2);
    issue(2'b10, 8'hA3);
    check("R3 cmp push err", W'(b_err), W'(0));
    issue(2'b00, 8'h00);
    check("R4 cmp pop first", b_ans, 8'hA1);
    issue(2'b10, 8'hA4);            // write index wraps to slot 0
    check("R9 cmp wrapped push err", W'(b_err), W'(0));
    issue(2'b10, 8'hA5);
    check("R6 cmp push on full err", W'(b_err), W'(1));
    check("R6 cmp push on full answer", b_ans, 8'hA1);
    issue(2'b00, 8'h00);
    check("R9 cmp pop 2", b_ans, 8'hA2);
    issue(2'b01, 8'h00);
    check("R5 cmp peek", b_ans, 8'hA3);
    issue(2'b00, 8'h00);
    check("R9 cmp pop 3", b_ans, 8'hA3);
    issue(2'b00, 8'h00);
    check("R9 cmp pop wrapped", b_ans, 8'hA4);
    issue(2'b00, 8'h00);
    check("R7 cmp pop empty err", W'(b_err), W'(1));
    check("R7 cmp pop empty answer", b_ans, 8'hA4);
    issue(2'b11, 8'h00);
    check("R8 cmp unused code err", W'(b_err), W'(1));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule